// File: doc/BRIEF.md
# GPIO Bank with Latched Pin Interrupts

This block controls one bank of general-purpose pins, with a parameterised width of up to 32. Software reaches it through a simple word-addressed register port. Each pin carries the following state:

- an output value and an output-enable bit, which together drive the pad;
- a synchronised input sample, which software can always read back;
- an interrupt configuration made of three bits: edge or level trigger, active polarity, and an enable.

Qualifying events set a sticky pending bit. Software clears a pending bit by writing a 1 to it. A single registered summary interrupt rises whenever an enabled pin is pending.

Pin sampling uses two synchronising flops. An edge is found by comparing the newest synchronised sample with the one before it. Because that comparison looks only at pin samples, changing a pin's polarity at any moment cannot by itself create an event. Software can therefore emulate detection on both edges by flipping the polarity after each event.

The register port is a plain control interface, not a data stream. It never stalls, so it carries no back-pressure signals. Writes take effect at the clock edge on which `bus_en` and `bus_we` are both high. Read data is combinational from the address while `bus_en` is high and `bus_we` is low, and it is zero otherwise.

Top module: `gpio_bank_irq`

## Requirements
- R1: `pin_out` and `pin_oe` show the output-value register (byte offset 0x00) and the output-enable register (offset 0x04). Both reset to zero and change only on a write to their own offset, one clock after that write.
- R2: The input register (offset 0x08) returns each pin's level two clocks after it appears on `pin_in`, whatever the pin's output enable.
- R3: In edge mode (trigger-mode bit at offset 0x0C set to 1), a pin with polarity bit 1 (offset 0x10) sets its pending bit on a 0-to-1 change of its synchronised sample. A pin with polarity bit 0 sets it on a 1-to-0 change. The pending bit is visible in the status register (offset 0x1C) one clock after the input register shows the new level.
- R4: In level mode (trigger-mode bit 0), a pin sets its pending bit while its synchronised sample equals its polarity bit. The bit stays set after the pin returns inactive, until it is cleared. Since all registers reset to zero, every pin low after reset becomes pending.
- R5: Changing a polarity bit while the pin is steady and in edge mode creates no pending event.
- R6: Writing to the clear register (offset 0x18) clears every pending bit written as 1 and leaves bits written as 0 unchanged.
- R7: When a detection and a clear hit the same bit in the same clock, the bit stays pending.
- R8: Pending bits latch regardless of the enable register (offset 0x14). Only enabled pending bits contribute to `irq`.
- R9: `irq` is registered. It is high in the clock after the one in which the bitwise AND of status and enable is nonzero.
- R10: The clear register reads as zero. Writes to the input or status offsets change no state.
- R11: Every register resets to zero. An unmapped offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | W | Write data, one bit per pin |
| bus_rdata | output | W | Read data, zero when not reading |
| pin_in | input | W | Raw pin levels from the pads |
| pin_out | output | W | Output value per pin |
| pin_oe | output | W | Output enable per pin |
| irq | output | 1 | Summary interrupt |

## Verification
The hardest situation to reach is a clear that lands in exactly the same clock as a fresh detection on the same bit. The bench reaches it by holding a level-mode pin active, so that its detection is present every cycle, and then issuing the write-one-to-clear. It then releases the pin and clears again, to show that the clear does work once detection stops. Polarity flips on steady pins in edge mode are driven in the same way, and the status register is read right after each flip.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFF_OUT  = 5'h00,
    OFF_OE   = 5'h04,
    OFF_IN   = 5'h08,
    OFF_MODE = 5'h0C,
    OFF_POL  = 5'h10,
    OFF_EN   = 5'h14,
    OFF_CLR  = 5'h18,
    OFF_STAT = 5'h1C
  } reg_off_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= raw;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] active_high,
  output logic [W-1:0] hit
);
  logic [W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= level;
  end

  generate
    for (genvar p = 0; p < W; p++) begin : g_pin
      logic rose, fell, lvl_hit, edg_hit;
      assign rose    = level[p] & ~last_q[p];
      assign fell    = ~level[p] & last_q[p];
      assign edg_hit = active_high[p] ? rose : fell;
      assign lvl_hit = active_high[p] ? level[p] : ~level[p];
      assign hit[p]  = edge_mode[p] ? edg_hit : lvl_hit;
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      in_level,
  input  logic [W-1:0]      hit,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      oe_q,
  output logic [W-1:0]      mode_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      status_q,
  output logic [W-1:0]      clr_mask
);
  logic wr, rd;
  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;

  assign clr_mask = (wr && bus_addr == OFF_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q    <= '0;
      oe_q     <= '0;
      mode_q   <= '0;
      pol_q    <= '0;
      en_q     <= '0;
      status_q <= '0;
    end else begin
      if (wr && bus_addr == OFF_OUT)  out_q  <= bus_wdata;
      if (wr && bus_addr == OFF_OE)   oe_q   <= bus_wdata;
      if (wr && bus_addr == OFF_MODE) mode_q <= bus_wdata;
      if (wr && bus_addr == OFF_POL)  pol_q  <= bus_wdata;
      if (wr && bus_addr == OFF_EN)   en_q   <= bus_wdata;
      status_q <= (status_q & ~clr_mask) | hit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        OFF_OUT:  bus_rdata = out_q;
        OFF_OE:   bus_rdata = oe_q;
        OFF_IN:   bus_rdata = in_level;
        OFF_MODE: bus_rdata = mode_q;
        OFF_POL:  bus_rdata = pol_q;
        OFF_EN:   bus_rdata = en_q;
        OFF_STAT: bus_rdata = status_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic              irq
);
  logic [W-1:0] level, det;
  logic [W-1:0] mode_q, pol_q, en_q, status_q, clr_mask;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(level)
  );

  gpio_detect #(.W(W)) u_detect (
    .clk(clk), .rst_n(rst_n), .level(level),
    .edge_mode(mode_q), .active_high(pol_q), .hit(det)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_level(level), .hit(det),
    .out_q(pin_out), .oe_q(pin_oe), .mode_q(mode_q), .pol_q(pol_q),
    .en_q(en_q), .status_q(status_q), .clr_mask(clr_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(status_q & en_q);
  end
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_en,
  input logic         bus_we,
  input logic [4:0]   bus_addr,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] status,
  input logic [W-1:0] enable,
  input logic [W-1:0] det,
  input logic [W-1:0] clr_mask,
  input logic         irq
);
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq == |($past(status & enable)))); // R9

  AST_DET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((status & $past(det)) == $past(det))); // R7

  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((status & $past(status & ~clr_mask)) == $past(status & ~clr_mask))); // R4

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((status & $past(clr_mask & ~det)) == '0)); // R6

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_en && bus_we && bus_addr == 5'h00)) |-> $stable(pin_out)); // R1
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .pin_out(pin_out), .status(status_q),
  .enable(en_q), .det(det), .clr_mask(clr_mask), .irq(irq)
);

// File: tb/gpio_bank_irq_bench.sv
module gpio_bank_irq_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, pin_in = '0;
  logic [W-1:0] bus_rdata, pin_out, pin_oe;
  logic         irq;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R11";

  always #10 clk = ~clk;

  gpio_bank_irq #(.W(W)) u_gpio_bank_irq (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference state
  logic [W-1:0] m_out, m_oe, m_mode, m_pol, m_en, m_stat, m_s1, m_s2, m_prev;
  logic         m_irq;

  function automatic logic [W-1:0] model_read();
    if (!(bus_en && !bus_we)) return '0;
    case (bus_addr)
      5'h00: return m_out;
      5'h04: return m_oe;
      5'h08: return m_s2;
      5'h0C: return m_mode;
      5'h10: return m_pol;
      5'h14: return m_en;
      5'h1C: return m_stat;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [W-1:0] hits, clr;
    if (!rst_n) begin
      m_out = '0; m_oe = '0; m_mode = '0; m_pol = '0; m_en = '0;
      m_stat = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_irq = 1'b0;
    end else begin
      hits = '0;
      for (int i = 0; i < W; i++) begin
        if (m_mode[i])
          hits[i] = m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
        else
          hits[i] = (m_s2[i] == m_pol[i]);
      end
      clr = (bus_en && bus_we && bus_addr == 5'h18) ? bus_wdata : '0;
      m_irq  = ((m_stat & m_en) != 0);
      m_stat = (m_stat & ~clr) | hits;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      if (bus_en && bus_we) begin
        case (bus_addr)
          5'h00: m_out  = bus_wdata;
          5'h04: m_oe   = bus_wdata;
          5'h0C: m_mode = bus_wdata;
          5'h10: m_pol  = bus_wdata;
          5'h14: m_en   = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic cmp(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, late in the low phase
  always @(negedge clk) begin
    #8;
    cmp("R1", "pin_out", pin_out, m_out);
    cmp("R1", "pin_oe", pin_oe, m_oe);
    cmp("R9", "irq", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_irq});
    cmp(cur_req, "bus_rdata", bus_rdata, model_read());
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [W-1:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle(3);
    cur_req = "R11";
    for (int a = 0; a < 32; a += 4) rd(5'(a));
    @(negedge clk); rst_n = 1'b1;
    rd(5'h1C); rd(5'h1C); rd(5'h02);  // R4 low pins pend after reset; R11 unmapped
    cur_req = "R1";
    wr(5'h00, 32'hA5A5_0F0F); wr(5'h04, 32'hFFFF_0000); rd(5'h00); rd(5'h04);
    cur_req = "R2";
    pin_in = 32'h1234_5678; rd(5'h08); rd(5'h08); rd(5'h08);
    pin_in = 32'hFFFF_0000; idle(1); rd(5'h08); rd(5'h08);
    cur_req = "R3";
    wr(5'h0C, '1); wr(5'h10, 32'h0000_FFFF);
    pin_in = '0; idle(4); wr(5'h18, '1); rd(5'h1C);
    pin_in = 32'h0010_000F; rd(5'h1C); rd(5'h1C); rd(5'h1C); rd(5'h1C);
    pin_in = 32'h0000_000F; rd(5'h1C); rd(5'h1C); rd(5'h1C);
    cur_req = "R6";
    wr(5'h18, 32'h0000_0003); rd(5'h1C); wr(5'h18, '1); rd(5'h1C);
    cur_req = "R5";
    wr(5'h10, 32'hFFFF_0000); rd(5'h1C); wr(5'h10, 32'h0F0F_F0F0); rd(5'h1C); rd(5'h1C);
    cur_req = "R4";
    wr(5'h0C, 32'hFFFF_FEFF); wr(5'h10, 32'h0000_0100); wr(5'h18, '1);
    @(negedge clk); pin_in[8] = 1'b1; @(negedge clk); pin_in[8] = 1'b0;
    rd(5'h1C); rd(5'h1C); idle(3); rd(5'h1C);
    cur_req = "R7";
    pin_in[8] = 1'b1; idle(3); wr(5'h18, 32'h0000_0100); rd(5'h1C);
    pin_in[8] = 1'b0; idle(4); wr(5'h18, 32'h0000_0100); rd(5'h1C);
    cur_req = "R8";
    pin_in[0] = 1'b0; idle(3); pin_in[0] = 1'b1; idle(4); rd(5'h1C);
    wr(5'h14, 32'h0000_0001); idle(2); rd(5'h14);
    cur_req = "R9";
    wr(5'h18, 32'h0000_0001); idle(2); wr(5'h14, '0); idle(2);
    cur_req = "R10";
    wr(5'h08, '1); wr(5'h1C, '1); wr(5'h18, '0); rd(5'h18); rd(5'h08); rd(5'h1C);
    idle(2);
    finish_run();
  end
endmodule